// File: doc/BRIEF.md
# Half-Bit-Tick UART Transmitter

This block turns bytes into asynchronous serial frames on a single transmit line. It has no baud generator of its own. A free-running strobe, one clock cycle wide, arrives once every half bit period. The same strobe also paces a receiver that runs on its own, so a byte handed to the transmitter is not aligned to that timebase. The block takes the byte, waits for the next strobe, and from then on moves the line to the next bit only on every second strobe. The strobes in between are ignored. As a result, each bit lasts exactly two strobe periods.

Bytes come in over a valid/ready stream port. A byte transfers on the clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from that edge until the frame has fully ended, which is how back-pressure works: a source holding `in_valid` simply waits. The source need not keep `in_data` steady after the transfer, because the byte is captured on the transfer edge. Two plain status pins report that a frame is pending or in progress (`busy_o`) and that a frame has just finished (`done_o`).

The number of stop bits (one or two) and the line polarity are fixed when the block is built.

Top module: `uart_tx_halftick`

## Requirements
- R1: After synchronous reset, `tx_o` is at the idle level, `in_ready` is 1, and `busy_o` and `done_o` are 0.
- R2: A byte is taken on a rising edge where `in_valid` and `in_ready` are both 1, and the value of `in_data` at that edge is the one sent. From the next cycle `in_ready` is 0 until the done cycle.
- R3: The start bit appears on `tx_o` in the cycle after the first `tick_i` pulse that comes strictly after the transfer cycle. A pulse in the transfer cycle itself does not start the frame, so the wait can be up to one full strobe period. Until the start bit, `tx_o` stays idle.
- R4: Each frame bit stays on `tx_o` for exactly two `tick_i` pulses. The first pulse of each pair leaves the line unchanged, and the line changes only on the second.
- R5: A frame is a start bit of logical 0, then the 8 data bits in order from bit 0 to bit 7, then the stop bits at logical 1. The idle level is logical 1.
- R6: `STOP_BITS` (1 or 2) sets how many logical-1 stop bits end the frame. Each stop bit lasts a full bit time.
- R7: With `INVERT` = 1, every level on `tx_o` is complemented, idle included. With `INVERT` = 0, logical levels are driven as they are.
- R8: `done_o` is high for exactly one cycle. That cycle follows the second strobe of the last stop bit, and `in_ready` returns to 1 in the same cycle.
- R9: `busy_o` is 1 from the cycle after the transfer through the last stop bit, and 0 in the done cycle.
- R10: Asserting `rst` during a pending request or a frame returns `tx_o` to idle and discards the byte. No frame starts on later strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Half-bit-period strobe, one cycle wide, shared with the receiver |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | DATA_BITS | Byte to send |
| tx_o | output | 1 | Serial line |
| busy_o | output | 1 | Frame pending or in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The hardest case to reach is a transfer that lands in the same cycle as a strobe. That strobe must not start the frame, so the start bit is delayed by a whole strobe period. The bench watches the strobe it generates and raises `in_valid` exactly when a strobe is due on the transfer edge; it then checks the maximal latency. Random gaps between bytes cover the other alignments. A reset applied between the transfer and the first strobe checks that a pending byte is really dropped.

// File: rtl/uart_txh_pkg.sv
package uart_txh_pkg;

  typedef enum logic [0:0] {
    TXH_IDLE = 1'b0,
    TXH_SEND = 1'b1
  } txh_state_e;

  // Maps a logical frame level to the driven pin level.
  function automatic logic txh_pin_level(input logic logical, input bit invert);
    return invert ? ~logical : logical;
  endfunction

endpackage

// File: rtl/txh_intake.sv
module txh_intake #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [DATA_BITS-1:0] in_data,
  output logic                 in_ready,
  input  logic                 frame_active_i,
  input  logic                 launch_i,
  output logic                 pending_o,
  output logic [DATA_BITS-1:0] data_o
);

  logic                 pending_q;
  logic [DATA_BITS-1:0] hold_q;
  logic                 take;

  assign in_ready  = !pending_q && !frame_active_i;
  assign take      = in_valid && in_ready;
  assign pending_o = pending_q;
  assign data_o    = hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b0;
      hold_q    <= '0;
    end else if (take) begin
      pending_q <= 1'b1;
      hold_q    <= in_data;
    end else if (launch_i) begin
      pending_q <= 1'b0;
    end
  end

  AST_TAKE_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    take |=> !in_ready); // R2
  AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (rst)
    (pending_q && !launch_i) |=> pending_q); // R3

endmodule

// File: rtl/txh_pacer.sv
module txh_pacer (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic active_i,
  input  logic launch_i,
  output logic advance_o
);

  logic phase_q;

  // phase_q = 1 means the next strobe is the second of the current bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
    end else if (launch_i) begin
      phase_q <= 1'b0;
    end else if (active_i && tick_i) begin
      phase_q <= ~phase_q;
    end
  end

  assign advance_o = active_i && tick_i && phase_q;

  AST_ADVANCE_SPACED: assert property (@(posedge clk) disable iff (rst)
    advance_o |=> !advance_o); // R4

endmodule

// File: rtl/txh_serializer.sv
module txh_serializer
  import uart_txh_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 1,
  parameter bit INVERT    = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 launch_i,
  input  logic                 advance_i,
  input  logic [DATA_BITS-1:0] data_i,
  output logic                 active_o,
  output logic                 done_o,
  output logic                 line_o
);

  localparam int FRAME_W = 1 + DATA_BITS + STOP_BITS;
  localparam int SHIFT_W = DATA_BITS + STOP_BITS;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  txh_state_e         state_q;
  logic [SHIFT_W-1:0] shift_q;
  logic [CNT_W-1:0]   idx_q;
  logic               raw_q;
  logic               done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TXH_IDLE;
      shift_q <= '0;
      idx_q   <= '0;
      raw_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        TXH_IDLE: begin
          if (launch_i) begin
            state_q <= TXH_SEND;
            shift_q <= {{STOP_BITS{1'b1}}, data_i};
            idx_q   <= '0;
            raw_q   <= 1'b0;
          end
        end
        TXH_SEND: begin
          if (advance_i) begin
            if (idx_q == LAST_IDX) begin
              state_q <= TXH_IDLE;
              raw_q   <= 1'b1;
              done_q  <= 1'b1;
            end else begin
              raw_q   <= shift_q[0];
              shift_q <= {1'b1, shift_q[SHIFT_W-1:1]};
              idx_q   <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= TXH_IDLE;
      endcase
    end
  end

  assign active_o = (state_q == TXH_SEND);
  assign done_o   = done_q;

  generate
    if (INVERT) begin : g_inv
      assign line_o = ~raw_q;
    end else begin : g_true
      assign line_o = raw_q;
    end
  endgenerate

  AST_LINE_STEADY: assert property (@(posedge clk) disable iff (rst)
    (active_o && !advance_i) |=> $stable(line_o)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
  AST_START_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $rose(active_o) |-> (line_o == txh_pin_level(1'b0, INVERT))); // R5

endmodule

// File: rtl/uart_tx_halftick.sv
module uart_tx_halftick
  import uart_txh_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 1,
  parameter bit INVERT    = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick_i,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DATA_BITS-1:0] in_data,
  output logic                 tx_o,
  output logic                 busy_o,
  output logic                 done_o
);

  logic                 pending;
  logic [DATA_BITS-1:0] held;
  logic                 active;
  logic                 launch;
  logic                 advance;

  assign launch = pending && tick_i && !active;
  assign busy_o = pending || active;

  txh_intake #(.DATA_BITS(DATA_BITS)) u_intake (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .in_data        (in_data),
    .in_ready       (in_ready),
    .frame_active_i (active),
    .launch_i       (launch),
    .pending_o      (pending),
    .data_o         (held)
  );

  txh_pacer u_pacer (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .active_i  (active),
    .launch_i  (launch),
    .advance_o (advance)
  );

  txh_serializer #(
    .DATA_BITS (DATA_BITS),
    .STOP_BITS (STOP_BITS),
    .INVERT    (INVERT)
  ) u_ser (
    .clk       (clk),
    .rst       (rst),
    .launch_i  (launch),
    .advance_i (advance),
    .data_i    (held),
    .active_o  (active),
    .done_o    (done_o),
    .line_o    (tx_o)
  );

  AST_LAUNCH_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(tick_i)); // R3
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (tx_o == txh_pin_level(1'b1, INVERT))); // R7
  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    done_o |-> in_ready); // R8

endmodule

// File: tb/uart_tx_halftick_tb.sv
`timescale 1ns/1ps
module uart_tx_halftick_tb;

  localparam int P = 5;  // clocks per strobe

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic valid_a = 1'b0, valid_b = 1'b0;
  logic [7:0] data_a = '0, data_b = '0;
  logic ready_a, tx_a, busy_a, done_a;
  logic ready_b, tx_b, busy_b, done_b;
  int n_chk = 0, n_fail = 0;
  int tcnt = 0;

  always #2 clk = ~clk;

  uart_tx_halftick #(.DATA_BITS(8), .STOP_BITS(2), .INVERT(1'b1)) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick), .in_valid(valid_a), .in_ready(ready_a),
    .in_data(data_a), .tx_o(tx_a), .busy_o(busy_a), .done_o(done_a));

  uart_tx_halftick #(.DATA_BITS(8), .STOP_BITS(1), .INVERT(1'b0)) u_dut_b (
    .clk(clk), .rst(rst), .tick_i(tick), .in_valid(valid_b), .in_ready(ready_b),
    .in_data(data_b), .tx_o(tx_b), .busy_o(busy_b), .done_o(done_b));

  initial begin
    forever begin
      @(posedge clk);
      #1;
      tcnt = (tcnt + 1) % P;
      tick = (tcnt == 0);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic g_tx(bit s);    return s ? tx_b : tx_a;       endfunction
  function automatic logic g_ready(bit s); return s ? ready_b : ready_a; endfunction
  function automatic logic g_busy(bit s);  return s ? busy_b : busy_a;   endfunction
  function automatic logic g_done(bit s);  return s ? done_b : done_a;   endfunction

  function automatic logic exp_bit(logic [7:0] d, int k, bit inv);
    logic l;
    if (k == 0) l = 1'b0;
    else if (k <= 8) l = d[k-1];
    else l = 1'b1;
    return l ^ inv;
  endfunction

  task automatic skip_ticks(int n);
    int c = 0;
    while (c < n) begin
      if (tick) c++;
      @(negedge clk);
    end
  endtask

  task automatic send(bit s, logic [7:0] d, bit align);
    int stops = s ? 1 : 2;
    bit inv   = s ? 1'b0 : 1'b1;
    int fw    = 1 + 8 + stops;
    int lat   = 0;
    if (align) while (!tick) @(negedge clk);
    chk(g_ready(s) == 1'b1, "R2", "ready before offer", g_ready(s), 1);
    if (s) begin valid_b = 1'b1; data_b = d; end
    else   begin valid_a = 1'b1; data_a = d; end
    @(negedge clk);
    valid_a = 1'b0; valid_b = 1'b0;
    data_a = ~d; data_b = ~d;
    chk(g_ready(s) == 1'b0, "R2", "ready after take", g_ready(s), 0);
    chk(g_busy(s) == 1'b1, "R9", "busy after take", g_busy(s), 1);
    while (!tick) begin
      chk(g_tx(s) == (1'b1 ^ inv), "R3", "idle before start", g_tx(s), 1 ^ inv);
      @(negedge clk);
      lat++;
    end
    chk(lat < P, "R3", "start latency", lat, P - 1);
    if (align) chk(lat == P - 1, "R3", "aligned start latency", lat, P - 1);
    @(negedge clk);
    for (int k = 0; k < fw; k++) begin
      chk(g_tx(s) == exp_bit(d, k, inv), (k > 8) ? "R6" : "R5",
          $sformatf("bit %0d", k), g_tx(s), exp_bit(d, k, inv));
      chk(g_ready(s) == 1'b0 && g_busy(s) == 1'b1, "R9", "busy in frame",
          g_busy(s), 1);
      skip_ticks(1);
      chk(g_tx(s) == exp_bit(d, k, inv), "R4", $sformatf("odd tick bit %0d", k),
          g_tx(s), exp_bit(d, k, inv));
      skip_ticks(1);
    end
    chk(g_done(s) == 1'b1, "R8", "done pulse", g_done(s), 1);
    chk(g_ready(s) == 1'b1, "R8", "ready with done", g_ready(s), 1);
    chk(g_busy(s) == 1'b0, "R9", "busy at done", g_busy(s), 0);
    chk(g_tx(s) == (1'b1 ^ inv), "R7", "idle level", g_tx(s), 1 ^ inv);
    @(negedge clk);
    chk(g_done(s) == 1'b0, "R8", "done one cycle", g_done(s), 0);
  endtask

  task automatic check_quiet(int cycles);
    for (int i = 0; i < cycles; i++) begin
      chk(tx_a == 1'b0 && tx_b == 1'b1, "R10", "line idle after reset",
          {30'd0, tx_a, tx_b}, 1);
      chk(busy_a == 1'b0 && busy_b == 1'b0, "R10", "no busy after reset",
          {30'd0, busy_a, busy_b}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h1D5EED);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(tx_a == 1'b0, "R1", "idle inverted line", tx_a, 0);
    chk(tx_b == 1'b1, "R1", "idle line", tx_b, 1);
    chk(ready_a && ready_b, "R1", "ready", {31'd0, ready_a}, 1);
    chk(!busy_a && !busy_b && !done_a && !done_b, "R1", "status low",
        {30'd0, busy_a, done_a}, 0);

    // directed corners
    send(1'b0, 8'h00, 1'b1);
    send(1'b0, 8'hFF, 1'b0);
    send(1'b1, 8'hA5, 1'b1);
    send(1'b1, 8'h01, 1'b0);
    send(1'b0, 8'h80, 1'b1);

    // random mix
    for (int i = 0; i < 20; i++) begin
      repeat ($urandom % 7) @(negedge clk);
      send(($urandom % 3) == 0, 8'($urandom), ($urandom % 3) == 0);
    end

    // R10: reset while a byte is pending
    while (!tick) @(negedge clk);
    valid_a = 1'b1; data_a = 8'h5A;
    valid_b = 1'b1; data_b = 8'h5A;
    @(negedge clk);
    valid_a = 1'b0; valid_b = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ready_a && ready_b, "R10", "ready after reset", {31'd0, ready_a}, 1);
    check_quiet(3 * P);

    // R10: reset in the middle of a frame
    valid_b = 1'b1; data_b = 8'h00;
    @(negedge clk);
    valid_b = 1'b0;
    skip_ticks(5);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_quiet(4 * P);

    send(1'b1, 8'hC3, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule